// File: doc/BRIEF.md
# Interrupt-Level Banked Register File

This block is the register file of a 16-bit processor in which every interrupt level owns a private bank of eight 16-bit registers. The active level picks the bank that both read ports and the write port reach. A level switch is a single register update, and the registers of the interrupted level stay in place untouched. Interrupt handling therefore starts without copying any context out to memory. Returning to the earlier level later resumes the interrupted code with its state intact.

Each bank holds the program counter, the status word, the accumulator, a data register, a base register, an index register, a temporary register and a link register. The program counter and the status word of the active bank are always visible on dedicated outputs, and the status word is also broken out into its flag fields. A call strobe saves the program counter into the link register and loads a jump target in one edge. A return strobe moves the link register back into the program counter.

Priority arbitration between levels, the ALU and memory all sit outside this block. The block only accepts a level number with a load strobe.

Top module: `bankrf_top`

## Requirements
- R1: A synchronous active-high reset clears every register of every bank to zero and makes level 0 active.
- R2: The register number selects S=0, D=1, P=2, B=3, L=4, A=5, T=6, X=7. `pc_out` shows P and `status_out` shows S of the active bank.
- R3: Both read ports are combinational and independent, and each returns the addressed register of the active bank. A write performed at a clock edge becomes visible on the reads after that edge.
- R4: When `lvl_load` is high at an edge, `lvl_sel` becomes the active level at that edge. From then on the reads, `pc_out` and `status_out` come from the new bank, and no bank contents are moved.
- R5: A write, call or return in the same cycle as a level load acts on the bank of the level that was active before the edge.
- R6: Going back to a level that was left earlier finds all of its registers exactly as they were left.
- R7: A call (`call_req`) copies P into L and loads `call_target` into P of the active bank at one edge.
- R8: A return (`ret_req` without `call_req`) copies L into P of the active bank at one edge.
- R9: Call and return take precedence over a port write to P or L in the same cycle. When both strobes are high, the call is performed and the return is ignored.
- R10: The flag outputs decode the active S word as follows: carry is bit 0, zero is bit 1, sign is bit 2, paging enable is bit 3, and the privilege level is bits 5:4.
- R11: With `wr_en` low, `wr_idx` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_sel | input | 4 | Level number to switch to |
| lvl_load | input | 1 | Makes `lvl_sel` the active level at the next edge |
| rd_a_idx | input | 3 | Register number for read port A |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 3 | Register number for read port B |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register number to write |
| wr_data | input | 16 | Write data |
| call_req | input | 1 | Call strobe: P to L, target to P |
| call_target | input | 16 | Jump target loaded into P on a call |
| ret_req | input | 1 | Return strobe: L to P |
| cur_level | output | 4 | Active interrupt level |
| pc_out | output | 16 | Program counter of the active bank |
| status_out | output | 16 | Status word of the active bank |
| flag_carry | output | 1 | Carry flag of the active status word |
| flag_zero | output | 1 | Zero flag of the active status word |
| flag_sign | output | 1 | Sign flag of the active status word |
| flag_paging | output | 1 | Paging enable of the active status word |
| priv_level | output | 2 | Privilege level of the active status word |

## Verification
Every state change in this block (writes, calls, returns and level loads) takes effect at the single edge on which it is presented. The reads, the P and S outputs and the flags follow from it through combinational logic only. The bench therefore presents each operation after a falling edge and lets exactly one rising edge pass. It then drops the strobes and, a quarter period later, points a read port at the register under test before comparing, well before the next edge. The assertions express the same one-edge latency with `|=>`: the effect of a cycle's inputs must be present on the ports in the following cycle.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int DEF_DATA_W     = 16;
    localparam int DEF_NUM_LEVELS = 16;
    localparam int NUM_REGS       = 8;
    localparam int IDX_W          = $clog2(NUM_REGS);

    // Architectural register numbering
    typedef enum logic [IDX_W-1:0] {
        RN_S = 3'd0,
        RN_D = 3'd1,
        RN_P = 3'd2,
        RN_B = 3'd3,
        RN_L = 3'd4,
        RN_A = 3'd5,
        RN_T = 3'd6,
        RN_X = 3'd7
    } regnum_e;

    // Low bits of the status word (R10)
    localparam int FLAG_W = 6;
    typedef struct packed {
        logic [1:0] priv;
        logic       paging;
        logic       sign;
        logic       zero;
        logic       carry;
    } status_flags_t;

    function automatic status_flags_t decode_status(input logic [FLAG_W-1:0] low);
        return status_flags_t'(low);
    endfunction

endpackage

// File: rtl/bankrf_level.sv
module bankrf_level #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LVL_W-1:0] sel,
    output logic [LVL_W-1:0] level
);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (load) begin
            level <= sel;
        end
    end

endmodule

// File: rtl/bankrf_bank.sv
module bankrf_bank
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             active,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             call_req,
    input  logic [DATA_W-1:0]                call_target,
    input  logic                             ret_req,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    localparam int IP = int'(RN_P);
    localparam int IL = int'(RN_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_o <= '0;
        end else if (active) begin
            if (wr_en) begin
                regs_o[wr_idx] <= wr_data;
            end
            // later assignments win: call/return override port writes (R9)
            if (call_req) begin
                regs_o[IL] <= regs_o[IP];
                regs_o[IP] <= call_target;
            end else if (ret_req) begin
                regs_o[IP] <= regs_o[IL];
            end
        end
    end

endmodule

// File: rtl/bankrf_rdmux.sv
module bankrf_rdmux
    import bankrf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_LEVELS = 16,
    parameter int LVL_W      = 4
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] banks [NUM_LEVELS],
    input  logic [LVL_W-1:0]                level,
    input  logic [IDX_W-1:0]                idx,
    output logic [DATA_W-1:0]               data
);

    always_comb begin
        data = banks[level][idx];
    end

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
    import bankrf_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  lvl_sel,
    input  logic              lvl_load,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_req,
    input  logic [DATA_W-1:0] call_target,
    input  logic              ret_req,
    output logic [LVL_W-1:0]  cur_level,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] status_out,
    output logic              flag_carry,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_paging,
    output logic [1:0]        priv_level
);

    logic [NUM_REGS-1:0][DATA_W-1:0] all_banks [NUM_LEVELS];
    status_flags_t                   flags;

    bankrf_level #(.LVL_W(LVL_W)) u_level (
        .clk   (clk),
        .rst   (rst),
        .load  (lvl_load),
        .sel   (lvl_sel),
        .level (cur_level)
    );

    // one private bank per interrupt level; the old level is still
    // held in cur_level at the edge of a level load (R5)
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_bank
        bankrf_bank #(.DATA_W(DATA_W)) u_bank (
            .clk         (clk),
            .rst         (rst),
            .active      (cur_level == LVL_W'(g)),
            .wr_en       (wr_en),
            .wr_idx      (wr_idx),
            .wr_data     (wr_data),
            .call_req    (call_req),
            .call_target (call_target),
            .ret_req     (ret_req),
            .regs_o      (all_banks[g])
        );
    end

    bankrf_rdmux #(.DATA_W(DATA_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_rd_a (
        .banks (all_banks),
        .level (cur_level),
        .idx   (rd_a_idx),
        .data  (rd_a_data)
    );

    bankrf_rdmux #(.DATA_W(DATA_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_rd_b (
        .banks (all_banks),
        .level (cur_level),
        .idx   (rd_b_idx),
        .data  (rd_b_data)
    );

    bankrf_rdmux #(.DATA_W(DATA_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_rd_p (
        .banks (all_banks),
        .level (cur_level),
        .idx   (RN_P),
        .data  (pc_out)
    );

    bankrf_rdmux #(.DATA_W(DATA_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_rd_s (
        .banks (all_banks),
        .level (cur_level),
        .idx   (RN_S),
        .data  (status_out)
    );

    always_comb begin
        flags       = decode_status(status_out[FLAG_W-1:0]);
        flag_carry  = flags.carry;
        flag_zero   = flags.zero;
        flag_sign   = flags.sign;
        flag_paging = flags.paging;
        priv_level  = flags.priv;
    end

endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker #(
    parameter int DATA_W = 16,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [LVL_W-1:0]  lvl_sel,
    input logic              lvl_load,
    input logic [2:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [2:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              call_req,
    input logic [DATA_W-1:0] call_target,
    input logic              ret_req,
    input logic [LVL_W-1:0]  cur_level,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] status_out
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cur_level == '0 && pc_out == '0 && status_out == '0));

    assert_level_load_R4: assert property (@(posedge clk) disable iff (rst)
        lvl_load |=> cur_level == $past(lvl_sel));

    assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !lvl_load |=> $stable(cur_level));

    assert_pc_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 3'd2 && !call_req && !ret_req && !lvl_load)
        |=> pc_out == $past(wr_data));

    assert_status_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 3'd0 && !lvl_load) |=> status_out == $past(wr_data));

    assert_call_target_R7: assert property (@(posedge clk) disable iff (rst)
        (call_req && !lvl_load) |=> pc_out == $past(call_target));

    assert_return_link_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && !lvl_load && rd_a_idx == 3'd4)
        |=> pc_out == $past(rd_a_data));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !call_req && !ret_req && !lvl_load)
        |=> ($stable(pc_out) && $stable(status_out)));

endmodule

bind bankrf_top bankrf_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/bankrf_top_test.sv
module bankrf_top_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  lvl_sel = '0;
    logic        lvl_load = 1'b0;
    logic [2:0]  rd_a_idx = '0;
    logic [15:0] rd_a_data;
    logic [2:0]  rd_b_idx = '0;
    logic [15:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        call_req = 1'b0;
    logic [15:0] call_target = '0;
    logic        ret_req = 1'b0;
    logic [3:0]  cur_level;
    logic [15:0] pc_out;
    logic [15:0] status_out;
    logic        flag_carry, flag_zero, flag_sign, flag_paging;
    logic [1:0]  priv_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    bankrf_top uut (.*);

    typedef struct packed {
        logic        load;
        logic [3:0]  lsel;
        logic        we;
        logic [2:0]  widx;
        logic [15:0] wdata;
        logic        call;
        logic        ret;
        logic [15:0] tgt;
        logic [2:0]  ridx;
        logic [15:0] exp_rd;
        logic [3:0]  exp_lvl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 1'b1, 3'd5, 16'h1111, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h1111, 4'd0, 8'd3},  // R3 write A
        '{1'b0, 4'd0, 1'b1, 3'd2, 16'h0100, 1'b0, 1'b0, 16'h0000, 3'd2, 16'h0100, 4'd0, 8'd2},  // R2 P is number 2
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0800, 3'd4, 16'h0100, 4'd0, 8'd7},  // R7 L gets old P
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd2, 16'h0800, 4'd0, 8'd7},  // R7 P gets target
        '{1'b1, 4'd3, 1'b1, 3'd5, 16'h2222, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h0000, 4'd3, 8'd4},  // R4 new bank clear
        '{1'b0, 4'd0, 1'b1, 3'd5, 16'h3333, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h3333, 4'd3, 8'd3},  // R3 write in level 3
        '{1'b1, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h2222, 4'd0, 8'd5},  // R5 write went to old level
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h0000, 3'd2, 16'h0100, 4'd0, 8'd8},  // R8 return
        '{1'b0, 4'd0, 1'b0, 3'd5, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h2222, 4'd0, 8'd11}, // R11 no enable
        '{1'b1, 4'd3, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h3333, 4'd3, 8'd6},  // R6 bank kept
        '{1'b0, 4'd0, 1'b1, 3'd2, 16'h0AAA, 1'b1, 1'b0, 16'h0BBB, 3'd2, 16'h0BBB, 4'd3, 8'd9},  // R9 call beats write
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd4, 16'h0000, 4'd3, 8'd9},  // R9 L took old P
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h0CCC, 3'd2, 16'h0CCC, 4'd3, 8'd9},  // R9 call beats return
        '{1'b0, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 3'd4, 16'h0BBB, 4'd3, 8'd9},  // R9 L after call
        '{1'b0, 4'd0, 1'b1, 3'd0, 16'h0035, 1'b0, 1'b0, 16'h0000, 3'd0, 16'h0035, 4'd3, 8'd10}  // R10 status write
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // present one operation for exactly one rising edge, then idle
    task automatic apply(input vec_t v, input logic [2:0] ridx_after);
        @(negedge clk);
        lvl_load = v.load; lvl_sel = v.lsel;
        wr_en = v.we; wr_idx = v.widx; wr_data = v.wdata;
        call_req = v.call; ret_req = v.ret; call_target = v.tgt;
        @(posedge clk);
        #(PERIOD/4);
        lvl_load = 1'b0; wr_en = 1'b0; call_req = 1'b0; ret_req = 1'b0;
        rd_a_idx = ridx_after;
        #1;
    endtask

    initial begin
        #(PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        vec_t idle;
        idle = '0;
        repeat (2) @(posedge clk);
        #(PERIOD/4);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 level", 16'(cur_level), 16'h0000);
        check("R1 pc", pc_out, 16'h0000);
        check("R1 status", status_out, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], VECS[i].ridx);
            check($sformatf("R%0d vec%0d data", VECS[i].req, i), rd_a_data, VECS[i].exp_rd);
            check($sformatf("R%0d vec%0d level", VECS[i].req, i), 16'(cur_level), 16'(VECS[i].exp_lvl));
        end

        // R10 flag decode of S = 0x0035
        check("R10 carry", 16'(flag_carry), 16'h1);
        check("R10 zero", 16'(flag_zero), 16'h0);
        check("R10 sign", 16'(flag_sign), 16'h1);
        check("R10 paging", 16'(flag_paging), 16'h0);
        check("R10 priv", 16'(priv_level), 16'h3);
        check("R2 pc_out", pc_out, 16'h0CCC);
        check("R2 status_out", status_out, 16'h0035);

        // R3 two independent read ports
        rd_a_idx = 3'd0; rd_b_idx = 3'd4;
        #1;
        check("R3 port A", rd_a_data, 16'h0035);
        check("R3 port B", rd_b_data, 16'h0BBB);

        // R4 top level number: fresh bank of level 15 is all zero
        idle.load = 1'b1; idle.lsel = 4'd15;
        apply(idle, 3'd0);
        check("R4 level 15", 16'(cur_level), 16'h000F);
        for (int r = 0; r < 8; r++) begin
            rd_a_idx = 3'(r);
            #1;
            check($sformatf("R1 level15 reg%0d", r), rd_a_data, 16'h0000);
        end

        // R1 reset mid-run clears every bank
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #(PERIOD/4);
        rst = 1'b0;
        #1;
        check("R1 level after reset", 16'(cur_level), 16'h0000);
        rd_a_idx = 3'd5;
        #1;
        check("R1 level0 A cleared", rd_a_data, 16'h0000);
        idle.lsel = 4'd3;
        apply(idle, 3'd5);
        check("R1 level3 A cleared", rd_a_data, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule